// File: doc/BRIEF.md
# Asymmetric I2C SCL Timing Generator

This block produces the clock line of an I2C bus master, together with the data-line edges that frame a transfer. The SCL period is not split evenly. The low phase takes a fraction of the period that depends on the bus speed mode, and the high phase takes the rest. This keeps the low time above the bus minimum even when the period is tight. Each mode's fraction is set midway between its minimum-low and minimum-high constraints: 0.535 for standard mode, 0.64 for fast mode and 0.62 for fast-plus mode.

The caller supplies the total SCL period as a count of system clocks, plus a mode code. From these the block derives the low count and the high count in a two-stage registered pipeline, and flags when the result is ready. A START request runs three steps in order. First comes a setup interval with both lines released. Next comes a hold interval with SDA low and SCL high. Finally the clock runs in alternating low and high phases. A STOP request ends the clock after the current low phase. It then holds SCL high with SDA low for a setup interval and releases SDA. The START setup, START hold and STOP setup intervals all equal the low count. The counts are captured when a START is accepted, so a change to the period or mode during a transfer applies only from the next START.

Top module: `scl_split_gen`

## Requirements
- R1: With mode code 0 (standard), t_low_o equals floor(period_i*535/1000), saturated to 255.
- R2: With mode code 1 (fast), t_low_o equals floor(period_i*64/100), saturated to 255.
- R3: With mode code 2 or 3 (fast-plus), t_low_o equals floor(period_i*62/100), saturated to 255.
- R4: The low count never exceeds 255. t_high_o equals period_i minus the saturated low count, and no SCL low phase lasts longer than 255 clocks.
- R5: A period_i value outside 2..510 sets err_o. A START request is then ignored, and scl_o and sda_o both stay 1.
- R6: Suppose period_i or mode_i changes between two clock edges. Then ready_o reads 0 after the next edge, and it reads 1 after the edge that follows if the inputs are held.
- R7: Once a START is accepted, the sequence runs as follows. SDA and SCL stay high for L clocks, where L is the low count. SDA then falls while SCL is high and stays low for L clocks. SCL then runs low for L clocks and high for H clocks, where H is the high count, repeating. A START is accepted on an edge where start_i, enable_i and ready_o are all 1 and err_o is 0.
- R8: When a stop_i pulse arrives during a transfer, the current SCL low phase completes. SCL then goes high with SDA low for L clocks, after which SDA rises while SCL is high and both lines stay released.
- R9: The L and H counts are captured when a START is accepted. Changes to period_i or mode_i during a transfer do not alter its phases.
- R10: With enable_i at 0, both outputs read 1 after the next edge and the generator goes idle. A stop_i pulse while idle has no effect.
- R11: During reset, scl_o and sda_o are 1, and ready_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Generator enable; 0 forces idle with lines released |
| start_i | input | 1 | START request, sampled while idle |
| stop_i | input | 1 | STOP request pulse during a transfer |
| period_i | input | 9 | SCL period in system clocks (valid 2..510) |
| mode_i | input | 2 | Speed mode: 0 standard, 1 fast, 2/3 fast-plus |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| ready_o | output | 1 | Low/high counts match the current inputs |
| err_o | output | 1 | Period count out of range |
| t_low_o | output | 8 | Computed low-phase count |
| t_high_o | output | 9 | Computed high-phase count |

## Verification
A wrong fraction or a wrong saturation shows on t_low_o and t_high_o two edges after the inputs settle. It also shows in the measured length of the SDA setup, the SDA hold and every SCL phase from the first START onward. If the capture register or the phase counter is corrupted, the very next phase boundary comes early or late by a whole number of clocks. A stuck state shows as a line that never returns high after a STOP or a disable, and it is seen one edge later. Counts captured at the wrong time show only in transfers whose inputs change mid-run, so those runs compare every phase against the values in force at START.

// File: rtl/scl_split_pkg.sv
package scl_split_pkg;

  localparam int MODE_CODES = 4;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_START_SU = 3'd1,
    ST_START_HD = 3'd2,
    ST_LOW      = 3'd3,
    ST_HIGH     = 3'd4,
    ST_STOP_SU  = 3'd5
  } scl_state_e;

  // numerator of the low-phase fraction for a mode code
  function automatic int frac_num(input int code);
    case (code)
      0:       frac_num = 535;
      1:       frac_num = 64;
      default: frac_num = 62;
    endcase
  endfunction

  // denominator of the low-phase fraction for a mode code
  function automatic int frac_den(input int code);
    case (code)
      0:       frac_den = 1000;
      default: frac_den = 100;
    endcase
  endfunction

endpackage

// File: rtl/scl_split_calc.sv
module scl_split_calc
  import scl_split_pkg::*;
#(
  parameter int PW   = 9,
  parameter int LW   = 8,
  parameter int PMIN = 2,
  parameter int PMAX = 510
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic [1:0]    mode_i,
  output logic [LW-1:0] low_o,
  output logic [PW-1:0] high_o,
  output logic          err_o,
  output logic          ready_o
);

  localparam int FW      = 10;
  localparam int PROD_W  = PW + FW;
  localparam int LOW_MAX = (1 << LW) - 1;

  logic [FW-1:0] num_tab [MODE_CODES];
  logic [FW-1:0] den_tab [MODE_CODES];

  genvar g;
  generate
    for (g = 0; g < MODE_CODES; g++) begin : g_frac
      assign num_tab[g] = FW'(frac_num(g));
      assign den_tab[g] = FW'(frac_den(g));
    end
  endgenerate

  // stage 1: capture inputs and product
  logic [PW-1:0]     s1_period_q, s1_period_d;
  logic [1:0]        s1_mode_q, s1_mode_d;
  logic [PROD_W-1:0] s1_prod_q, s1_prod_d;

  // stage 2: quotient, saturation, remainder phase, range check
  logic [LW-1:0]     s2_low_q, s2_low_d;
  logic [PW-1:0]     s2_high_q, s2_high_d;
  logic              s2_err_q, s2_err_d;
  logic              rdy_q, rdy_d;
  logic [PROD_W-1:0] quot;

  always_comb begin
    s1_period_d = period_i;
    s1_mode_d   = mode_i;
    s1_prod_d   = PROD_W'(period_i) * PROD_W'(num_tab[mode_i]);
  end

  always_comb begin
    quot = s1_prod_q / PROD_W'(den_tab[s1_mode_q]);
    if (quot > PROD_W'(LOW_MAX)) begin
      s2_low_d = LW'(LOW_MAX);
    end else begin
      s2_low_d = quot[LW-1:0];
    end
    s2_high_d = s1_period_q - PW'(s2_low_d);
    s2_err_d  = (s1_period_q < PW'(PMIN)) || (s1_period_q > PW'(PMAX));
    rdy_d     = (period_i == s1_period_q) && (mode_i == s1_mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_period_q <= '0;
      s1_mode_q   <= '0;
      s1_prod_q   <= '0;
      s2_low_q    <= '0;
      s2_high_q   <= '0;
      s2_err_q    <= 1'b0;
      rdy_q       <= 1'b0;
    end else begin
      s1_period_q <= s1_period_d;
      s1_mode_q   <= s1_mode_d;
      s1_prod_q   <= s1_prod_d;
      s2_low_q    <= s2_low_d;
      s2_high_q   <= s2_high_d;
      s2_err_q    <= s2_err_d;
      rdy_q       <= rdy_d;
    end
  end

  assign low_o   = s2_low_q;
  assign high_o  = s2_high_q;
  assign err_o   = s2_err_q;
  assign ready_o = rdy_q;

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = (val_i == '0) ? '0 : val_i - W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/scl_wave_fsm.sv
module scl_wave_fsm
  import scl_split_pkg::*;
#(
  parameter int PW = 9,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ready_i,
  input  logic          err_i,
  input  logic [LW-1:0] low_i,
  input  logic [PW-1:0] high_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          busy_o
);

  scl_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic [LW-1:0] lat_low_q, lat_low_d;
  logic [PW-1:0] lat_high_q, lat_high_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic          lat_en;
  logic          tm_load;
  logic [PW-1:0] tm_val;
  logic          tm_done;

  scl_phase_timer #(.W(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tm_load),
    .val_i  (tm_val),
    .done_o (tm_done)
  );

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    lat_en     = 1'b0;
    lat_low_d  = lat_low_q;
    lat_high_d = lat_high_q;
    tm_load    = 1'b0;
    tm_val     = PW'(lat_low_q);

    if (stop_i && (state_q != ST_IDLE)) begin
      pend_d = 1'b1;
    end

    if (!enable_i) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          pend_d = 1'b0;
          if (start_i && ready_i && !err_i) begin
            lat_en     = 1'b1;
            lat_low_d  = low_i;
            lat_high_d = high_i;
            tm_load    = 1'b1;
            tm_val     = PW'(low_i);
            state_d    = ST_START_SU;
          end
        end
        ST_START_SU: begin
          if (tm_done) begin
            tm_load = 1'b1;
            state_d = ST_START_HD;
          end
        end
        ST_START_HD: begin
          if (tm_done) begin
            tm_load = 1'b1;
            state_d = ST_LOW;
          end
        end
        ST_LOW: begin
          if (tm_done) begin
            tm_load = 1'b1;
            if (pend_q || stop_i) begin
              pend_d  = 1'b0;
              state_d = ST_STOP_SU;
            end else begin
              tm_val  = lat_high_q;
              state_d = ST_HIGH;
            end
          end
        end
        ST_HIGH: begin
          if (tm_done) begin
            tm_load = 1'b1;
            state_d = ST_LOW;
          end
        end
        ST_STOP_SU: begin
          if (tm_done) begin
            pend_d  = 1'b0;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    scl_d = (state_d != ST_LOW);
    sda_d = (state_d == ST_IDLE) || (state_d == ST_START_SU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_low_q  <= '0;
      lat_high_q <= '0;
    end else if (lat_en) begin
      lat_low_q  <= lat_low_d;
      lat_high_q <= lat_high_d;
    end
  end

  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/scl_split_gen.sv
module scl_split_gen #(
  parameter int PW   = 9,
  parameter int LW   = 8,
  parameter int PMIN = 2,
  parameter int PMAX = 510
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [PW-1:0] period_i,
  input  logic [1:0]    mode_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          ready_o,
  output logic          err_o,
  output logic [LW-1:0] t_low_o,
  output logic [PW-1:0] t_high_o
);

  logic [LW-1:0] low_c;
  logic [PW-1:0] high_c;
  logic          err_c;
  logic          rdy_c;
  logic          busy;

  scl_split_calc #(.PW(PW), .LW(LW), .PMIN(PMIN), .PMAX(PMAX)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .mode_i   (mode_i),
    .low_o    (low_c),
    .high_o   (high_c),
    .err_o    (err_c),
    .ready_o  (rdy_c)
  );

  scl_wave_fsm #(.PW(PW), .LW(LW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .ready_i  (rdy_c),
    .err_i    (err_c),
    .low_i    (low_c),
    .high_i   (high_c),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .busy_o   (busy)
  );

  assign t_low_o  = low_c;
  assign t_high_o = high_c;
  assign err_o    = err_c;
  assign ready_o  = rdy_c;

endmodule

// File: rtl/scl_split_chk.sv
module scl_split_chk #(
  parameter int PW = 9,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable_i,
  input logic [PW-1:0] period_i,
  input logic [1:0]    mode_i,
  input logic          scl_o,
  input logic          sda_o,
  input logic          ready_o,
  input logic          err_o,
  input logic [LW-1:0] t_low_o,
  input logic [PW-1:0] t_high_o,
  input logic          busy
);

  localparam int RW      = PW + 1;
  localparam int LOW_MAX = (1 << LW) - 1;

  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (!scl_o) begin
      if (low_run_q != {RW{1'b1}}) low_run_q <= low_run_q + RW'(1);
    end else begin
      low_run_q <= '0;
    end
  end

  a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (scl_o && sda_o));

  a_r4_phase_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !err_o && $stable(period_i) && $stable(mode_i)) |->
      ((RW'(t_low_o) + RW'(t_high_o)) == RW'(period_i)));

  a_r4_low_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_o |-> (low_run_q < RW'(LOW_MAX)));

  a_r5_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !busy) |=> !busy);

  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(period_i) && $stable(mode_i)) |=> !ready_o);

  a_r7_sda_fall_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_o) |-> scl_o);

  a_r8_sda_rise_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_o) |-> scl_o);

endmodule

bind scl_split_gen scl_split_chk #(.PW(PW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable_i (enable_i),
  .period_i (period_i),
  .mode_i   (mode_i),
  .scl_o    (scl_o),
  .sda_o    (sda_o),
  .ready_o  (ready_o),
  .err_o    (err_o),
  .t_low_o  (t_low_o),
  .t_high_o (t_high_o),
  .busy     (busy)
);

// File: tb/scl_split_gen_test.sv
module scl_split_gen_test;

  logic       clk;
  logic       rst_n;
  logic       enable_i;
  logic       start_i;
  logic       stop_i;
  logic [8:0] period_i;
  logic [1:0] mode_i;
  logic       scl_o;
  logic       sda_o;
  logic       ready_o;
  logic       err_o;
  logic [7:0] t_low_o;
  logic [8:0] t_high_o;

  int total;
  int bad;
  bit finished;

  scl_split_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .period_i (period_i),
    .mode_i   (mode_i),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .ready_o  (ready_o),
    .err_o    (err_o),
    .t_low_o  (t_low_o),
    .t_high_o (t_high_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_low(input int p, input int m);
    int raw;
    if (m == 0)      raw = (p * 535) / 1000;
    else if (m == 1) raw = (p * 64) / 100;
    else             raw = (p * 62) / 100;
    if (raw > 255) raw = 255;
    return raw;
  endfunction

  function automatic string mode_tag(input int m);
    if (m == 0) return "R1";
    if (m == 1) return "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count negedges while the line pair holds the given levels
  task automatic run_len(input bit ws, input bit wd, output int n);
    n = 0;
    while (scl_o == ws && sda_o == wd && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic trial(input int p, input int m, input bit change_mid);
    int el, eh, n;
    bit ok;
    period_i = 9'(p);
    mode_i   = 2'(m);
    repeat (3) @(negedge clk);
    ok = (p >= 2) && (p <= 510);
    el = exp_low(p, m);
    eh = p - el;
    check("R5 err flag", int'(err_o), ok ? 0 : 1);
    if (!ok) begin
      pulse_start();
      repeat (6) @(negedge clk);
      check("R5 start ignored", int'({scl_o, sda_o}), 3);
      return;
    end
    check(mode_tag(m), int'(t_low_o), el);
    check("R4 high count", int'(t_high_o), eh);
    pulse_start();
    run_len(1'b1, 1'b1, n);
    check("R7 start setup", n, el);
    run_len(1'b1, 1'b0, n);
    check("R7 start hold", n, el);
    run_len(1'b0, 1'b0, n);
    check("R7 low phase", n, el);
    if (change_mid) begin
      period_i = 9'($urandom_range(2, 510));
      mode_i   = 2'($urandom_range(0, 3));
    end
    run_len(1'b1, 1'b0, n);
    check(change_mid ? "R9 high kept" : "R7 high phase", n, eh);
    run_len(1'b0, 1'b0, n);
    check(change_mid ? "R9 low kept" : "R7 low phase 2", n, el);
    run_len(1'b1, 1'b0, n);
    check("R7 high phase 2", n, eh);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    run_len(1'b0, 1'b0, n);
    check("R8 last low", n, el - 1);
    run_len(1'b1, 1'b0, n);
    check("R8 stop setup", n, el);
    check("R8 released", int'({scl_o, sda_o}), 3);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4711));
    total    = 0;
    bad      = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    enable_i = 1'b1;
    start_i  = 1'b0;
    stop_i   = 1'b0;
    period_i = 9'd100;
    mode_i   = 2'd0;
    repeat (3) @(negedge clk);
    check("R11 reset lines", int'({scl_o, sda_o}), 3);
    check("R11 reset ready", int'(ready_o), 0);
    check("R11 reset err", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 ready timing
    period_i = 9'd200;
    @(negedge clk);
    check("R6 ready drop", int'(ready_o), 0);
    @(negedge clk);
    check("R6 ready back", int'(ready_o), 1);
    check("R1 after change", int'(t_low_o), 107);

    // boundaries, saturation and range errors
    for (int m = 0; m < 4; m++) begin
      trial(2, m, 1'b0);
      trial(510, m, 1'b1);
    end
    trial(477, 0, 1'b0);
    trial(0, 1, 1'b0);
    trial(1, 0, 1'b0);
    trial(511, 2, 1'b0);

    // R10 disable mid-run
    period_i = 9'd40;
    mode_i   = 2'd1;
    repeat (3) @(negedge clk);
    pulse_start();
    run_len(1'b1, 1'b1, n);
    run_len(1'b1, 1'b0, n);
    check("R10 in low phase", int'(scl_o), 0);
    enable_i = 1'b0;
    @(negedge clk);
    check("R10 disable release", int'({scl_o, sda_o}), 3);
    repeat (4) @(negedge clk);
    check("R10 stays idle", int'({scl_o, sda_o}), 3);
    enable_i = 1'b1;
    @(negedge clk);

    // R10 stop while idle
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 idle stop", int'({scl_o, sda_o}), 3);
    trial(40, 1, 1'b0);

    // random mix
    for (int k = 0; k < 16; k++) begin
      trial(int'($urandom_range(2, 510)), int'($urandom_range(0, 3)),
            bit'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule